// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A synthesizable model of a pipelined burst SRAM whose data bus can change direction on every cycle. Reads and writes may follow each other in any order with no idle cycle between them. To make that possible, write data travels on the bus in the same relative cycle as read data. Write data is sampled two enabled clock edges after its address. A read result is loaded into the output register on the first enabled edge after its address edge, so it can be sampled at the second. Because a write's data arrives late, its address waits in two write-address registers. When a read targets a word whose write is still in flight, the read path forwards the arriving lanes straight from the bus.

Each access starts with a load cycle (`adv` low). The load carries the address, the access type and the burst order. Later cycles with `adv` high continue the same access type on the next address of a four-word burst. A low clock enable freezes the whole block for that edge. The bus is modelled as separate input, output and drive-enable pins. The drive enable is the registered read-valid flag, gated by an asynchronous output enable.

The command stage is a state machine with three states: `ACC_IDLE` (deselected), `ACC_READ` and `ACC_WRITE`. It has four transitions. LOAD_READ enters `ACC_READ` when the chip is selected with `write_req` low. LOAD_WRITE enters `ACC_WRITE` when the chip is selected with `write_req` high. DESELECT enters `ACC_IDLE` on a load while the chip is not selected. ADVANCE keeps the current state and steps the burst counter.

Top module: `zt_sram`

## Requirements
- R1: A read loaded at an enabled edge puts the addressed word on `dout` after the next enabled edge. `dout_oe` is high for that cycle while `out_en` is 1.
- R2: A write's data on `din` is sampled at the second enabled edge after its address edge. `lane_wr[i]` (sampled with the address) enables bits [9i+8:9i]. Lanes with a 0 keep their old contents. `din` is ignored at every other edge.
- R3: Reads and writes can alternate on every cycle. A read of a word whose write has not yet been committed returns the new lanes merged with the old ones.
- R4: A new access is selected only when `sel_a`=1, `sel_b`=1 and `sel_c_n`=0. Any other combination on a load is a deselect: `dout_oe` is low after the next enabled edge and no write takes place, even with `write_req` high.
- R5: `dout_oe` is low in the cycle in which a write's data is due on `din`, which is the cycle after the first enabled edge following its address edge.
- R6: `out_en`=0 forces `dout_oe` low at once, with no clock edge needed.
- R7: An edge with `clk_en`=0 is ignored. Outputs, command state, pending writes and the burst position all hold.
- R8: With `adv`=1 the previous access type (read, write or deselect) continues. The low two address bits follow linear order (base+count mod 4) if `burst_lin` was 1 at the load, and interleaved order (base XOR count) if it was 0. The upper bits stay fixed.
- R9: After reset `dout_oe` and `dout` are 0, no write is pending and the command state is `ACC_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en | input | 1 | 1: edge acts; 0: edge ignored |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| write_req | input | 1 | 1: write access on a load, 0: read |
| lane_wr | input | LANES | Per-lane write enables |
| adv | input | 1 | 1: continue burst, 0: load new access |
| burst_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr | input | AW | Word address |
| out_en | input | 1 | Asynchronous output enable, active high |
| din | input | LANES*LANE_W | Write data (bus inbound) |
| dout | output | LANES*LANE_W | Read data register (bus outbound) |
| dout_oe | output | 1 | Bus drive enable |

## Verification
A read issued at enabled edge n must appear on `dout`, with `dout_oe` high, between edges n+1 and n+2. The write issued at edge n needs its data on `din` just before edge n+2. Edges with `clk_en` low are not counted in either case. The bench keeps a history of the last two enabled operations. It drives `din` only for the write that is two enabled edges old, and otherwise drives random data. At each enabled edge it commits that write into its reference array and resolves the read issued one edge earlier. It then compares `dout` and `dout_oe` at the following falling edge. Across stalled edges the bench keeps the previous expectation and checks that it holds.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // next word of a burst: linear wraps within the burst, interleaved toggles bits
    function automatic logic [BURST_W-1:0] burst_step(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               linear
    );
        logic [BURST_W-1:0] r;
        if (linear) r = base + cnt;
        else        r = base ^ cnt;
        return r;
    endfunction

endpackage

// File: rtl/zt_sram_cmd.sv
`timescale 1ns/1ps
module zt_sram_cmd
    import zt_sram_pkg::*;
#(
    parameter int AW    = 9,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             write_req,
    input  logic             adv,
    input  logic             burst_lin,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] lane_wr,
    output acc_e             cur_acc,
    output logic [AW-1:0]    cur_addr,
    output logic [LANES-1:0] cur_lanes
);
    localparam int HI_W = AW - BURST_W;

    acc_e               state_q, state_d;
    logic [HI_W-1:0]    hi_q, hi_d;
    logic [BURST_W-1:0] base_q, base_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic               lin_q, lin_d;
    logic [LANES-1:0]   lanes_q;
    logic               selected;

    assign selected = sel_a & sel_b & ~sel_c_n;

    // next-state: LOAD_READ, LOAD_WRITE, DESELECT on a load; ADVANCE otherwise
    always_comb begin
        state_d = state_q;
        hi_d    = hi_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        lin_d   = lin_q;
        if (!adv) begin
            hi_d   = addr[AW-1:BURST_W];
            base_d = addr[BURST_W-1:0];
            cnt_d  = '0;
            lin_d  = burst_lin;
            if (!selected)      state_d = ACC_IDLE;
            else if (write_req) state_d = ACC_WRITE;
            else                state_d = ACC_READ;
        end else begin
            unique case (state_q)
                ACC_IDLE:            state_d = ACC_IDLE;
                ACC_READ, ACC_WRITE: cnt_d   = cnt_q + 1'b1;
                default:             state_d = ACC_IDLE;
            endcase
        end
    end

    // state register, frozen on a disabled edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            hi_q    <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            lin_q   <= 1'b0;
            lanes_q <= '0;
        end else if (clk_en) begin
            state_q <= state_d;
            hi_q    <= hi_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            lin_q   <= lin_d;
            lanes_q <= lane_wr;
        end
    end

    // outputs: first address register of the access pipeline
    always_comb begin
        cur_acc   = state_q;
        cur_addr  = {hi_q, burst_step(base_q, cnt_q, lin_q)};
        cur_lanes = lanes_q;
    end

endmodule

// File: rtl/zt_sram_array.sv
`timescale 1ns/1ps
module zt_sram_array #(
    parameter int AW     = 9,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_go,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    // one storage column per lane so each lane has its own write strobe
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_go && wr_lanes[g])
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/zt_sram_rdpath.sv
`timescale 1ns/1ps
module zt_sram_rdpath #(
    parameter int AW     = 9,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    rd_go,
    input  logic [AW-1:0]           rd_addr,
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic                    wr_pend,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    rd_valid
);
    localparam int DW = LANES * LANE_W;

    logic          hit;
    logic [DW-1:0] merged;
    logic [DW-1:0] dout_q;
    logic          valid_q;

    // the write committing on this same edge is not yet in the array
    assign hit = rd_go && wr_pend && (rd_addr == wr_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] = (hit && wr_lanes[g])
                                            ? wr_data[g*LANE_W +: LANE_W]
                                            : arr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            valid_q <= 1'b0;
        end else if (clk_en) begin
            valid_q <= rd_go;
            if (rd_go) dout_q <= merged;
        end
    end

    assign dout     = dout_q;
    assign rd_valid = valid_q;

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW     = 9,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    sel_a,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    write_req,
    input  logic [LANES-1:0]        lane_wr,
    input  logic                    adv,
    input  logic                    burst_lin,
    input  logic [AW-1:0]           addr,
    input  logic                    out_en,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DW = LANES * LANE_W;

    acc_e             cur_acc;
    logic [AW-1:0]    cur_addr;
    logic [LANES-1:0] cur_lanes;

    logic             wpend_q;
    logic [AW-1:0]    waddr_q;
    logic [LANES-1:0] wlanes_q;

    logic [DW-1:0]    arr_data;
    logic             rd_valid;
    logic             rd_go;
    logic             wr_go;

    zt_sram_cmd #(.AW(AW), .LANES(LANES)) i_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .write_req (write_req),
        .adv       (adv),
        .burst_lin (burst_lin),
        .addr      (addr),
        .lane_wr   (lane_wr),
        .cur_acc   (cur_acc),
        .cur_addr  (cur_addr),
        .cur_lanes (cur_lanes)
    );

    // second write-address register: holds the write waiting for its data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wpend_q  <= 1'b0;
            waddr_q  <= '0;
            wlanes_q <= '0;
        end else if (clk_en) begin
            wpend_q  <= (cur_acc == ACC_WRITE);
            waddr_q  <= cur_addr;
            wlanes_q <= cur_lanes;
        end
    end

    assign rd_go = (cur_acc == ACC_READ);
    assign wr_go = clk_en && wpend_q;

    zt_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk      (clk),
        .wr_go    (wr_go),
        .wr_addr  (waddr_q),
        .wr_lanes (wlanes_q),
        .wr_data  (din),
        .rd_addr  (cur_addr),
        .rd_data  (arr_data)
    );

    zt_sram_rdpath #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .rd_go    (rd_go),
        .rd_addr  (cur_addr),
        .arr_data (arr_data),
        .wr_pend  (wpend_q),
        .wr_addr  (waddr_q),
        .wr_lanes (wlanes_q),
        .wr_data  (din),
        .dout     (dout),
        .rd_valid (rd_valid)
    );

    assign dout_oe = out_en && rd_valid;

endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          out_en,
    input logic          dout_oe,
    input logic [DW-1:0] dout,
    input acc_e          cur_acc,
    input logic          wpend
);

    p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cur_acc == ACC_READ) |=> (dout_oe || !out_en));

    p_write_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cur_acc == ACC_WRITE) |=> wpend);

    p_deselect_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cur_acc == ACC_IDLE) |=> !dout_oe);

    p_write_phase_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cur_acc == ACC_WRITE) |=> !dout_oe);

    p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !dout_oe);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(dout) && $stable(cur_acc) && $stable(wpend)));

endmodule

bind zt_sram zt_sram_chk #(.DW(LANES*LANE_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .out_en  (out_en),
    .dout_oe (dout_oe),
    .dout    (dout),
    .cur_acc (cur_acc),
    .wpend   (wpend_q)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
    localparam int AW     = 9;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0, sel_a = 1'b0, sel_b = 1'b0, sel_c_n = 1'b1;
    logic write_req = 1'b0, adv = 1'b0, burst_lin = 1'b0, out_en = 1'b0;
    logic [LANES-1:0] lane_wr = '0;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    din = '0;
    logic [DW-1:0]    dout;
    logic             dout_oe;

    always #2.5 clk = ~clk;

    zt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_zt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .write_req(write_req), .lane_wr(lane_wr), .adv(adv),
        .burst_lin(burst_lin), .addr(addr), .out_en(out_en), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    // reference state: 0 none, 1 read, 2 write
    logic [DW-1:0]    ref_mem [1<<AW];
    int               h_op   [2];
    logic [AW-1:0]    h_addr [2];
    logic [LANES-1:0] h_lanes[2];
    logic [DW-1:0]    h_data [2];
    bit               h_bur  [2];
    string            h_tag  [2];
    int               b_op;
    logic [AW-3:0]    b_hi;
    logic [1:0]       b_base, b_cnt;
    bit               b_lin;
    bit               exp_v;
    logic [DW-1:0]    exp_dout;
    string            exp_tag, exp_otag;
    int               checks = 0, errors = 0;
    bit               done = 1'b0;

    task automatic chk(input string tg, input logic [DW-1:0] act, input logic [DW-1:0] ex);
        checks++;
        if (act !== ex) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tg, act, ex);
        end
    endtask

    task automatic verify();
        string t;
        if (!out_en)    t = "R6";
        else if (exp_v) t = exp_tag;
        else            t = exp_otag;
        chk(t, DW'(dout_oe), DW'(out_en & exp_v));
        if (exp_v) chk(exp_tag, dout, exp_dout);
    endtask

    task automatic model_edge(input bit cs, input bit wr, input bit adv_i,
                              input logic [LANES-1:0] ln, input logic [AW-1:0] a,
                              input bit lin, input string tg);
        logic [1:0] idx;
        bit bur;
        bur = 1'b0;
        if (h_op[1] == 2)
            for (int l = 0; l < LANES; l++)
                if (h_lanes[1][l])
                    ref_mem[h_addr[1]][l*LANE_W +: LANE_W] = h_data[1][l*LANE_W +: LANE_W];
        if (h_op[0] == 1) begin
            exp_v    = 1'b1;
            exp_dout = ref_mem[h_addr[0]];
            if (h_tag[0] != "")                              exp_tag = h_tag[0];
            else if (h_op[1] == 2 && h_addr[1] == h_addr[0]) exp_tag = "R3";
            else if (h_bur[0])                               exp_tag = "R8";
            else                                             exp_tag = "R1";
        end else begin
            exp_v    = 1'b0;
            exp_otag = (h_op[0] == 2) ? "R5" : "R4";
        end
        if (!adv_i) begin
            b_op   = cs ? (wr ? 2 : 1) : 0;
            b_hi   = a[AW-1:2];
            b_base = a[1:0];
            b_cnt  = 2'd0;
            b_lin  = lin;
        end else if (b_op != 0) begin
            b_cnt = b_cnt + 2'd1;
            bur   = 1'b1;
        end
        idx = b_lin ? (b_base + b_cnt) : (b_base ^ b_cnt);
        h_op[1] = h_op[0]; h_addr[1] = h_addr[0]; h_lanes[1] = h_lanes[0];
        h_data[1] = h_data[0]; h_bur[1] = h_bur[0]; h_tag[1] = h_tag[0];
        h_op[0] = b_op; h_addr[0] = {b_hi, idx}; h_lanes[0] = ln;
        h_data[0] = DW'({$urandom, $urandom}); h_bur[0] = bur; h_tag[0] = tg;
    endtask

    task automatic step(input bit en, input bit cs, input bit wr, input bit adv_i,
                        input logic [LANES-1:0] ln, input logic [AW-1:0] a,
                        input bit lin, input bit oe, input string tg);
        @(negedge clk);
        verify();
        clk_en = en; adv = adv_i; write_req = wr; lane_wr = ln;
        addr = a; burst_lin = lin; out_en = oe;
        if (cs) begin
            sel_a = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
        end else begin
            case ($urandom % 3)
                0:       begin sel_a = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; end
                1:       begin sel_a = 1'b1; sel_b = 1'b0; sel_c_n = 1'b0; end
                default: begin sel_a = 1'b1; sel_b = 1'b1; sel_c_n = 1'b1; end
            endcase
        end
        // din carries the write two enabled edges old, anything else is noise
        if (en && h_op[1] == 2) din = h_data[1];
        else                    din = DW'({$urandom, $urandom});
        @(posedge clk);
        #1;
        if (en) model_edge(cs, wr, adv_i, ln, a, lin, tg);
        else if (exp_v) exp_tag = "R7";
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, '0, '0, 0, 1, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 2; i++) begin
            h_op[i] = 0; h_addr[i] = '0; h_lanes[i] = '0;
            h_data[i] = '0; h_bur[i] = 1'b0; h_tag[i] = "";
        end
        b_op = 0; b_hi = '0; b_base = '0; b_cnt = '0; b_lin = 1'b0;
        exp_v = 1'b0; exp_dout = '0; exp_tag = "R1"; exp_otag = "R9";
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", DW'(dout_oe), '0);
        chk("R9", dout, '0);
        rst_n = 1'b1;

        // R8 linear burst writes fill words 0..15
        for (int hi = 0; hi < 4; hi++) begin
            step(1, 1, 1, 0, 4'hF, AW'(hi * 4), 1, 1, "");
            for (int k = 0; k < 3; k++) step(1, 0, 0, 1, 4'hF, '0, 0, 1, "");
        end
        idle(2);
        // R8 interleaved burst read from base 2, then linear from base 3
        step(1, 1, 0, 0, '0, AW'(6), 0, 1, "");
        for (int k = 0; k < 3; k++) step(1, 1, 1, 1, '0, '0, 1, 1, "");
        step(1, 1, 0, 0, '0, AW'(11), 1, 1, "");
        for (int k = 0; k < 3; k++) step(1, 1, 0, 1, '0, '0, 0, 1, "");
        // R3 back-to-back write then read of the same word, R2 partial lanes
        step(1, 1, 1, 0, 4'b0101, AW'(5), 1, 1, "");
        step(1, 1, 0, 0, '0, AW'(5), 1, 1, "");
        step(1, 1, 0, 0, '0, AW'(5), 1, 1, "R2");
        step(1, 1, 1, 0, 4'b1000, AW'(4), 1, 1, "");
        step(1, 1, 0, 0, '0, AW'(4), 1, 1, "");
        idle(2);
        // R4 write while deselected must not change word 6
        step(1, 0, 1, 0, 4'hF, AW'(6), 1, 1, "");
        idle(1);
        step(1, 1, 0, 0, '0, AW'(6), 1, 1, "R4");
        idle(2);
        // R7 stall holds a read result, and a write spans two stalled edges
        step(1, 1, 0, 0, '0, AW'(7), 1, 1, "");
        idle(1);
        step(0, 1, 1, 0, 4'hF, AW'(3), 0, 1, "");
        step(0, 0, 1, 0, 4'hF, AW'(2), 0, 1, "");
        step(1, 1, 1, 0, 4'b0011, AW'(9), 1, 1, "");
        step(0, 1, 0, 0, '0, AW'(9), 1, 1, "");
        step(0, 1, 0, 0, '0, AW'(9), 1, 1, "");
        step(1, 1, 0, 0, '0, AW'(9), 1, 1, "");
        step(1, 1, 0, 0, '0, AW'(9), 1, 1, "R7");
        idle(2);
        // R6 output enable low hides a read result
        step(1, 1, 0, 0, '0, AW'(8), 1, 0, "");
        step(1, 0, 0, 0, '0, '0, 1, 0, "");
        step(1, 0, 0, 0, '0, '0, 1, 1, "");
        idle(1);

        // constrained random mix over a small pool of words
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) != 0, ($urandom % 6) != 0, $urandom % 2 == 1,
                 ($urandom % 3) == 0, LANES'($urandom), AW'($urandom % 16),
                 $urandom % 2 == 1, ($urandom % 10) != 0, "");
        end
        idle(4);
        finish_run();
    end

endmodule